// File: doc/BRIEF.md
# Lite UART Register Front End

This block is the bus-facing register layer of a minimal UART. A processor reaches it through a word-indexed slave port that holds four registers: receive data, transmit data, status and control. Bytes from an external serial receiver arrive on a byte-valid input and are queued in an eight-entry receive FIFO. Each write to the transmit register sends its low byte to a one-cycle output strobe. The transmitter is modelled as always empty and has no queue. A single level interrupt line combines a sticky pending flag with an enable bit in the control register.

A read is accepted in the cycle that `bus_sel` is high with `bus_wr` low. The data is registered at that clock edge and presented with `bus_rvalid` in the following cycle. A small access state machine tracks this. It has two states. `ACC_IDLE` means no read data is pending. `ACC_RESP` means read data is on `bus_rdata`. Its transitions are:

- `ACC_IDLE` to `ACC_RESP` on an accepted read.
- `ACC_RESP` to `ACC_RESP` on a back-to-back read.
- `ACC_RESP` to `ACC_IDLE` when no read is accepted.

Writes take effect at the edge where they are accepted and never move the machine out of `ACC_IDLE`. The block works on the byte address of a 16-byte window. Only address bits 3:2 reach it, as a word index on `bus_waddr`. The low two byte-address bits are not wired in.

Top module: `lite_uart_frontend`

## Requirements
- R1: Word index 0 selects receive data, 1 selects transmit data, 2 selects status and 3 selects control.
- R2: Read data for an accepted read appears on `bus_rdata`, with `bus_rvalid` high, in the cycle after the read is accepted. `bus_rvalid` is low when no read was accepted in the previous cycle.
- R3: The receive FIFO holds up to 8 bytes. Reads of word 0 return the bytes in arrival order, zero-extended, and each read of a non-empty FIFO removes one byte.
- R4: A byte that arrives while the FIFO holds 8 bytes is discarded, and the 8 stored bytes are kept intact.
- R5: Reading word 0 with an empty FIFO leaves the fill count at zero. Status bit 0 stays 0 afterwards.
- R6: Status encoding:
  - bit0: FIFO non-empty.
  - bit1: FIFO holds 8 bytes.
  - bit2: always 1, transmitter empty.
  - bit3: always 0.
  - bit4: interrupt pending.
  - bits 7:5: always 0.
  - Upper bits: always 0.
- R7: A write to word 1 raises `tx_strobe` for exactly the next cycle with the written low byte on `tx_byte`. A read of word 1 returns the whole last written word.
- R8: The pending bit (status bit 4) is set by a transmit write and by the FIFO being non-empty. It stays set until a status read, and a status read clears it only if the FIFO is empty at that read.
- R9: `irq` is high exactly when the pending bit is set and control bit 4 is set.
- R10: A write to word 3 stores the whole word, which reads back unchanged. If bit 1 of the written word is set, the FIFO is emptied, so the next byte received is the next byte read.
- R11: Writes to word 2 change no state. Status reads back as it would without the write.
- R12: After synchronous reset, status reads 0x04, control reads 0, and `irq`, `tx_strobe` and `bus_rvalid` are low.
- R13: A byte arriving in the same cycle as a receive read of a non-empty, non-full FIFO is queued behind the bytes already held, and the fill count is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_waddr | input | 2 | Word index (byte address bits 3:2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| rx_valid | input | 1 | Received byte strobe from the serial receiver |
| rx_byte | input | 8 | Received byte |
| tx_strobe | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Transmit byte, valid with `tx_strobe` |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong write pointer or a wrong fill count in the receive FIFO shows up as out-of-order or missing bytes on the next reads of word 0. It also shows up in status bits 0 and 1, which are visible one read later. A pending flag that fails to stick or fails to clear shows at `irq` in the cycle right after the transmit write, byte arrival or status read that should have changed it. The tests stress these points directly: they overfill the FIFO, drain it past empty, push and pop in the same cycle, and acknowledge the interrupt with bytes still queued.

// File: rtl/urf_pkg.sv
package urf_pkg;

    // Register word indices (byte address bits 3:2)
    localparam int unsigned WORD_RXD  = 0;
    localparam int unsigned WORD_TXD  = 1;
    localparam int unsigned WORD_STAT = 2;
    localparam int unsigned WORD_CTRL = 3;

    // Status bit positions
    localparam int unsigned SB_RX_NONEMPTY = 0;
    localparam int unsigned SB_RX_FULL     = 1;
    localparam int unsigned SB_TX_EMPTY    = 2;
    localparam int unsigned SB_TX_FULL     = 3;
    localparam int unsigned SB_PENDING     = 4;

    // Control bit positions
    localparam int unsigned CB_TX_CLEAR = 0;
    localparam int unsigned CB_RX_CLEAR = 1;
    localparam int unsigned CB_IRQ_EN   = 4;

    typedef enum logic [0:0] {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_t;

    // One-hot-or-none decoded bus events for the current cycle
    typedef struct packed {
        logic rx_pop;
        logic tx_wr;
        logic stat_rd;
        logic stat_wr;
        logic ctrl_wr;
    } acc_evt_t;

endpackage

// File: rtl/urf_rx_queue.sv
module urf_rx_queue #(
    parameter int unsigned DEPTH  = 8,   // power of two
    parameter int unsigned BYTE_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          push,
    input  logic [BYTE_W-1:0]             push_data,
    input  logic                          pop,
    output logic [BYTE_W-1:0]             head_data,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          nonempty,
    output logic                          full
);
    localparam int unsigned PTR_W = $clog2(DEPTH);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [BYTE_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic [PTR_W-1:0]  rd_idx;
    logic              take;
    logic              give;

    // Fullness and emptiness judged on the count before the edge
    assign full     = (count_q == CNT_W'(DEPTH));
    assign nonempty = (count_q != '0);
    assign take     = push && !full;
    assign give     = pop && nonempty;

    // Oldest entry sits count places behind the write pointer
    assign rd_idx    = wr_ptr_q - count_q[PTR_W-1:0];
    assign head_data = slot_q[rd_idx];
    assign count     = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (take && !clr) begin
            slot_q[wr_ptr_q] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (take) wr_ptr_q <= wr_ptr_q + PTR_W'(1);
            unique case ({take, give})
                2'b10:   count_q <= count_q + CNT_W'(1);
                2'b01:   count_q <= count_q - CNT_W'(1);
                default: count_q <= count_q;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH)); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !clr) |=> (count_q == CNT_W'(DEPTH))); // R4
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (!nonempty && pop && !push && !clr) |=> (count_q == '0)); // R5

endmodule

// File: rtl/urf_bus_access.sv
module urf_bus_access
    import urf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 2,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              wr,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [BYTE_W-1:0] rx_head,
    input  logic [DATA_W-1:0] tx_word,
    input  logic [DATA_W-1:0] status_word,
    input  logic [DATA_W-1:0] ctrl_word,
    output acc_evt_t          evt,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    acc_state_t        state_q, state_d;
    logic              rd_acc;
    logic [DATA_W-1:0] mux_word;
    logic [DATA_W-1:0] rdata_q;

    assign rd_acc = sel && !wr;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ACC_IDLE;
        else     state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: if (rd_acc) state_d = ACC_RESP;
            ACC_RESP: state_d = rd_acc ? ACC_RESP : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    // Outputs: decoded events and read mux
    always_comb begin
        evt          = '0;
        evt.rx_pop   = rd_acc && (waddr == IDX_W'(WORD_RXD));
        evt.stat_rd  = rd_acc && (waddr == IDX_W'(WORD_STAT));
        evt.tx_wr    = sel && wr && (waddr == IDX_W'(WORD_TXD));
        evt.stat_wr  = sel && wr && (waddr == IDX_W'(WORD_STAT));
        evt.ctrl_wr  = sel && wr && (waddr == IDX_W'(WORD_CTRL));
        unique case (waddr)
            IDX_W'(WORD_RXD):  mux_word = DATA_W'(rx_head);
            IDX_W'(WORD_TXD):  mux_word = tx_word;
            IDX_W'(WORD_STAT): mux_word = status_word;
            IDX_W'(WORD_CTRL): mux_word = ctrl_word;
            default:           mux_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (rd_acc) rdata_q <= mux_word;
    end

    assign rdata  = rdata_q;
    assign rvalid = (state_q == ACC_RESP);

    AST_READ_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        rd_acc |=> rvalid); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !rd_acc |=> !rvalid); // R2

endmodule

// File: rtl/urf_ctrl_irq.sv
module urf_ctrl_irq
    import urf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_evt_t          evt,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_nonempty,
    input  logic              rx_full,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [DATA_W-1:0] tx_word,
    output logic [DATA_W-1:0] status_word,
    output logic              rx_clear,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] tx_q;
    logic              strobe_q;
    logic              pend_q;
    logic              pend_vis;

    assign rx_clear = evt.ctrl_wr && wdata[CB_RX_CLEAR];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            tx_q     <= '0;
            strobe_q <= 1'b0;
            pend_q   <= 1'b0;
        end else begin
            if (evt.ctrl_wr) ctrl_q <= wdata;
            if (evt.tx_wr)   tx_q   <= wdata;
            strobe_q <= evt.tx_wr;
            // Sticky pending: set by transmit or queued data, cleared by status read
            pend_q   <= evt.tx_wr || rx_nonempty || (pend_q && !evt.stat_rd);
        end
    end

    assign pend_vis = pend_q || rx_nonempty;

    always_comb begin
        status_word                 = '0;
        status_word[SB_RX_NONEMPTY] = rx_nonempty;
        status_word[SB_RX_FULL]     = rx_full;
        status_word[SB_TX_EMPTY]    = 1'b1;
        status_word[SB_TX_FULL]     = 1'b0;
        status_word[SB_PENDING]     = pend_vis;
    end

    assign ctrl_word = ctrl_q;
    assign tx_word   = tx_q;
    assign tx_strobe = strobe_q;
    assign tx_byte   = tx_q[BYTE_W-1:0];
    assign irq       = pend_vis && ctrl_q[CB_IRQ_EN];

    AST_TX_PULSE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        tx_strobe |-> $past(evt.tx_wr)); // R7
    AST_TXW_PENDING: assert property (@(posedge clk) disable iff (rst)
        evt.tx_wr |=> status_word[SB_PENDING]); // R8

endmodule

// File: rtl/lite_uart_frontend.sv
module lite_uart_frontend
    import urf_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [IDX_W-1:0]  bus_waddr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              tx_strobe,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    acc_evt_t          evt;
    logic [BYTE_W-1:0] head;
    logic [CNT_W-1:0]  fill;
    logic              nonempty;
    logic              full;
    logic              rx_clear;
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] tx_word;
    logic [DATA_W-1:0] status_word;

    urf_rx_queue #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .clr       (rx_clear),
        .push      (rx_valid),
        .push_data (rx_byte),
        .pop       (evt.rx_pop),
        .head_data (head),
        .count     (fill),
        .nonempty  (nonempty),
        .full      (full)
    );

    urf_bus_access #(.DATA_W(DATA_W), .IDX_W(IDX_W), .BYTE_W(BYTE_W)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .sel         (bus_sel),
        .wr          (bus_wr),
        .waddr       (bus_waddr),
        .rx_head     (head),
        .tx_word     (tx_word),
        .status_word (status_word),
        .ctrl_word   (ctrl_word),
        .evt         (evt),
        .rdata       (bus_rdata),
        .rvalid      (bus_rvalid)
    );

    urf_ctrl_irq #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .wdata       (bus_wdata),
        .rx_nonempty (nonempty),
        .rx_full     (full),
        .ctrl_word   (ctrl_word),
        .tx_word     (tx_word),
        .status_word (status_word),
        .rx_clear    (rx_clear),
        .tx_strobe   (tx_strobe),
        .tx_byte     (tx_byte),
        .irq         (irq)
    );

    AST_RX_RESET_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (evt.ctrl_wr && bus_wdata[CB_RX_CLEAR]) |=> (fill == '0)); // R10
    AST_STAT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (evt.stat_wr && !rx_valid) |=> $stable(status_word)); // R11
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (evt.ctrl_wr && !bus_wdata[CB_IRQ_EN]) |=> !irq); // R9

endmodule

// File: tb/lite_uart_frontend_tb.sv
module lite_uart_frontend_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        tx_strobe;
    logic [7:0]  tx_byte;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #10 clk = ~clk; // 50 MHz

    lite_uart_frontend u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_waddr(bus_waddr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_strobe(tx_strobe), .tx_byte(tx_byte), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = w; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] w, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = w;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
        chk("R2 rvalid after read", {31'b0, bus_rvalid}, 32'h1);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R12 irq after reset", {31'b0, irq}, 0);
        chk("R12 tx_strobe after reset", {31'b0, tx_strobe}, 0);
        chk("R12 rvalid after reset", {31'b0, bus_rvalid}, 0);
        rd_reg(2'd2, d); chk("R12 R6 status after reset", d, 32'h04);
        rd_reg(2'd3, d); chk("R12 control after reset", d, 32'h0);
        @(negedge clk);
        chk("R2 rvalid low when idle", {31'b0, bus_rvalid}, 0);
    endtask

    task automatic t_transmit();
        logic [31:0] d;
        wr_reg(2'd1, 32'h0000_01A5);
        chk("R7 strobe after tx write", {31'b0, tx_strobe}, 1);
        chk("R7 tx byte", {24'b0, tx_byte}, 32'hA5);
        @(negedge clk);
        chk("R7 strobe lasts one cycle", {31'b0, tx_strobe}, 0);
        rd_reg(2'd1, d); chk("R7 R1 tx readback", d, 32'h1A5);
        chk("R9 irq masked when disabled", {31'b0, irq}, 0);
        rd_reg(2'd2, d); chk("R8 pending after tx write", d, 32'h14);
        rd_reg(2'd2, d); chk("R8 pending cleared by status read", d, 32'h04);
    endtask

    task automatic t_fifo_order();
        logic [31:0] d;
        push(8'h11); push(8'h22); push(8'h33);
        rd_reg(2'd2, d); chk("R6 status with data", d, 32'h15);
        rd_reg(2'd0, d); chk("R3 first byte", d, 32'h11);
        rd_reg(2'd0, d); chk("R3 second byte", d, 32'h22);
        rd_reg(2'd0, d); chk("R3 third byte", d, 32'h33);
        rd_reg(2'd0, d);
        rd_reg(2'd2, d); chk("R5 empty read no underflow", d, 32'h14);
        rd_reg(2'd2, d); chk("R8 cleared once empty", d, 32'h04);
        push(8'h5A);
        rd_reg(2'd0, d); chk("R5 count intact after empty read", d, 32'h5A);
        rd_reg(2'd2, d); chk("R5 drained again", d, 32'h14);
        rd_reg(2'd2, d);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        for (int i = 0; i < 10; i++) push(8'h40 + 8'(i));
        rd_reg(2'd2, d); chk("R4 R6 status full", d, 32'h17);
        for (int i = 0; i < 8; i++) begin
            rd_reg(2'd0, d); chk("R4 kept byte", d, 32'h40 + i);
        end
        rd_reg(2'd2, d); chk("R4 extra bytes dropped", d, 32'h14);
        rd_reg(2'd2, d);
    endtask

    task automatic t_push_pop();
        logic [31:0] d;
        push(8'h61); push(8'h62);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = 2'd0;
        rx_valid = 1'b1; rx_byte = 8'h63;
        @(negedge clk);
        bus_sel = 1'b0; rx_valid = 1'b0;
        chk("R13 simultaneous pop data", bus_rdata, 32'h61);
        rd_reg(2'd0, d); chk("R13 next byte", d, 32'h62);
        rd_reg(2'd0, d); chk("R13 pushed byte queued", d, 32'h63);
        rd_reg(2'd2, d); chk("R13 count back to zero", d, 32'h14);
        rd_reg(2'd2, d);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr_reg(2'd3, 32'h10);
        rd_reg(2'd3, d); chk("R10 control readback", d, 32'h10);
        chk("R9 irq idle", {31'b0, irq}, 0);
        wr_reg(2'd1, 32'h55);
        chk("R9 irq after tx write", {31'b0, irq}, 1);
        rd_reg(2'd2, d);
        chk("R9 irq acknowledged", {31'b0, irq}, 0);
        push(8'h70);
        chk("R9 irq on receive", {31'b0, irq}, 1);
        rd_reg(2'd2, d); chk("R8 status with data", d, 32'h15);
        chk("R8 status read keeps pending while nonempty", {31'b0, irq}, 1);
        rd_reg(2'd0, d); chk("R3 byte under irq", d, 32'h70);
        chk("R8 pending sticky after drain", {31'b0, irq}, 1);
        rd_reg(2'd2, d);
        chk("R8 pending cleared after drain", {31'b0, irq}, 0);
        wr_reg(2'd1, 32'h66);
        wr_reg(2'd3, 32'h0);
        chk("R9 irq masked by control", {31'b0, irq}, 0);
        rd_reg(2'd2, d);
    endtask

    task automatic t_rx_reset();
        logic [31:0] d;
        push(8'h81); push(8'h82); push(8'h83);
        wr_reg(2'd3, 32'h12);
        rd_reg(2'd2, d); chk("R10 receive reset empties", d, 32'h14);
        rd_reg(2'd3, d); chk("R10 control value kept", d, 32'h12);
        push(8'h84);
        rd_reg(2'd0, d); chk("R10 fresh byte after reset", d, 32'h84);
        rd_reg(2'd2, d); rd_reg(2'd2, d);
        wr_reg(2'd3, 32'h0);
    endtask

    task automatic t_status_write();
        logic [31:0] d;
        wr_reg(2'd2, 32'hFF);
        rd_reg(2'd2, d); chk("R11 status write ignored", d, 32'h04);
        wr_reg(2'd1, 32'h01);
        wr_reg(2'd2, 32'h00);
        rd_reg(2'd2, d); chk("R11 status write keeps pending", d, 32'h14);
        rd_reg(2'd2, d); chk("R1 word 2 is status", d, 32'h04);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_transmit();
        t_fifo_order();
        t_overflow();
        t_push_pop();
        t_irq();
        t_rx_reset();
        t_status_write();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule